// File: doc/BRIEF.md
# Radix-2 Frequency-Decimation Butterfly

This block is one butterfly of a frequency-decimated FFT for signed fixed-point complex samples. It takes two complex operands, `a` and `b`, and one complex twiddle. The twiddle parts are 9-bit signed values with 1 integer bit and 8 fractional bits. The upper leg is the sum `a + b`, sign-extended to the output width. The lower leg forms the difference `a - b` first, then multiplies it by the twiddle as a full complex product. The accumulated product is shifted arithmetically right by 8, which removes the twiddle scaling.

Operand width `N` and result width `M` are parameters. One design therefore serves every stage of a widening chain, for example 8 to 11, 11 to 14, and 14 to 16 bits. A first-stage instance gets zero imaginary inputs. A parameter selects a purely combinational build or a build with one result register. The register has an active-high synchronous reset and loads only on qualified input.

Top module: `dif_bfly`

## Requirements
- R1: `xRe` equals `aRe + bRe` and `xIm` equals `aIm + bIm`, computed in signed two's complement and sign-extended to `M` bits.
- R2: `yRe` equals `(dRe*wRe - dIm*wIm) >>> 8`, where `dRe = aRe - bRe` and `dIm = aIm - bIm`.
- R3: `yIm` equals `(dRe*wIm + dIm*wRe) >>> 8`.
- R4: The shift by 8 is arithmetic and rounds toward minus infinity. For example, a difference of -1 with twiddle (255, 0) gives `yRe = -1`.
- R5: Twiddle (255, 0) is not an exact pass-through. A real difference of 100 gives `yRe = 99`, and a real difference of -128 gives `yRe = -128`.
- R6: When `aIm` and `bIm` are both zero (a real-only stage), `xIm` is 0.
- R7: With the result register in place, which is the default, outputs reflect the inputs sampled one clock earlier. `outValid` is `inValid` delayed by one cycle.
- R8: A high `rst` at a rising edge clears `xRe`, `xIm`, `yRe`, `yIm` and `outValid` to zero. Reset takes priority over `inValid`.
- R9: When `inValid` is low at a rising edge and reset is low, the four result ports keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies operands and twiddle this cycle |
| aRe | input | N | Operand a, real part (signed) |
| aIm | input | N | Operand a, imaginary part (signed) |
| bRe | input | N | Operand b, real part (signed) |
| bIm | input | N | Operand b, imaginary part (signed) |
| wRe | input | TW_W | Twiddle real part, signed Q1.8 |
| wIm | input | TW_W | Twiddle imaginary part, signed Q1.8 |
| outValid | output | 1 | Results are valid |
| xRe | output | M | Sum leg, real |
| xIm | output | M | Sum leg, imaginary |
| yRe | output | M | Product leg, real |
| yIm | output | M | Product leg, imaginary |

## Verification
The bench crosses the extreme operand values -128, -127, -1, 0, 1 and 127 on all four operand parts. Each combination is run against every listed twiddle, plus the -256 twiddle and a (255, 255) twiddle. A long pseudo-random run follows.

These sweeps target specific mistakes:
- Treating the operands as unsigned would wrap the sum leg.
- Shifting each partial product before accumulation would lose carries between them.
- Using a logical shift, or rounding toward zero, would turn small negative products into 0 or into huge positive values.
- Modelling (255, 0) as a pass-through would report 100 where the design gives 99.

Hold cycles and a reset asserted while `inValid` is high expose the last two kinds of fault. A missing load enable would overwrite results on idle cycles. A missing reset priority would let new data through during reset.

// File: rtl/dif_bfly_pkg.sv
package dif_bfly_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic load;   // capture new results
    logic clear;  // synchronous clear of result register
  } bflyStrobe_t;

endpackage

// File: rtl/dif_bfly_ctrl.sv
module dif_bfly_ctrl
  import dif_bfly_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output bflyStrobe_t strobe,
  output logic        outValid
);

  always_comb begin
    strobe.load  = inValid;
    strobe.clear = rst;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk) begin
        if (rst) validQ <= 1'b0;
        else     validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/dif_bfly_cmul.sv
// Complex product of a difference with a Q1.8 twiddle, scaled back by SHIFT.
module dif_bfly_cmul #(
  parameter int DW    = 9,
  parameter int TW_W  = 9,
  parameter int SHIFT = 8,
  parameter int OW    = 11
) (
  input  logic signed [DW-1:0]   dRe,
  input  logic signed [DW-1:0]   dIm,
  input  logic signed [TW_W-1:0] wRe,
  input  logic signed [TW_W-1:0] wIm,
  output logic signed [OW-1:0]   pRe,
  output logic signed [OW-1:0]   pIm
);

  localparam int PROD_W = DW + TW_W;
  localparam int ACC_W  = PROD_W + 1;

  logic signed [PROD_W-1:0] rr, ii, ri, ir;
  logic signed [ACC_W-1:0]  accRe, accIm;

  always_comb begin
    rr = PROD_W'(dRe) * PROD_W'(wRe);
    ii = PROD_W'(dIm) * PROD_W'(wIm);
    ri = PROD_W'(dRe) * PROD_W'(wIm);
    ir = PROD_W'(dIm) * PROD_W'(wRe);
    accRe = ACC_W'(rr) - ACC_W'(ii);
    accIm = ACC_W'(ri) + ACC_W'(ir);
    pRe = OW'(accRe >>> SHIFT);
    pIm = OW'(accIm >>> SHIFT);
  end

endmodule

// File: rtl/dif_bfly_datapath.sv
module dif_bfly_datapath
  import dif_bfly_pkg::*;
#(
  parameter int N       = 8,
  parameter int M       = 11,
  parameter int TW_W    = 9,
  parameter int SHIFT   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  bflyStrobe_t            strobe,
  input  logic signed [N-1:0]    aRe,
  input  logic signed [N-1:0]    aIm,
  input  logic signed [N-1:0]    bRe,
  input  logic signed [N-1:0]    bIm,
  input  logic signed [TW_W-1:0] wRe,
  input  logic signed [TW_W-1:0] wIm,
  output logic signed [M-1:0]    xRe,
  output logic signed [M-1:0]    xIm,
  output logic signed [M-1:0]    yRe,
  output logic signed [M-1:0]    yIm
);

  localparam int SUM_W = N + 1;

  logic signed [SUM_W-1:0] sumRe, sumIm, difRe, difIm;
  logic signed [M-1:0]     xReC, xImC, yReC, yImC;

  always_comb begin
    sumRe = SUM_W'(aRe) + SUM_W'(bRe);
    sumIm = SUM_W'(aIm) + SUM_W'(bIm);
    difRe = SUM_W'(aRe) - SUM_W'(bRe);
    difIm = SUM_W'(aIm) - SUM_W'(bIm);
    xReC  = M'(sumRe);
    xImC  = M'(sumIm);
  end

  dif_bfly_cmul #(
    .DW(SUM_W), .TW_W(TW_W), .SHIFT(SHIFT), .OW(M)
  ) u_cmul (
    .dRe(difRe), .dIm(difIm), .wRe(wRe), .wIm(wIm),
    .pRe(yReC), .pIm(yImC)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (strobe.clear) begin
          xRe <= '0; xIm <= '0; yRe <= '0; yIm <= '0;
        end else if (strobe.load) begin
          xRe <= xReC; xIm <= xImC; yRe <= yReC; yIm <= yImC;
        end
      end
    end else begin : g_comb
      assign xRe = xReC;
      assign xIm = xImC;
      assign yRe = yReC;
      assign yIm = yImC;
    end
  endgenerate

endmodule

// File: rtl/dif_bfly.sv
module dif_bfly
  import dif_bfly_pkg::*;
#(
  parameter int N       = 8,
  parameter int M       = 11,
  parameter int TW_W    = 9,
  parameter int SHIFT   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   inValid,
  input  logic signed [N-1:0]    aRe,
  input  logic signed [N-1:0]    aIm,
  input  logic signed [N-1:0]    bRe,
  input  logic signed [N-1:0]    bIm,
  input  logic signed [TW_W-1:0] wRe,
  input  logic signed [TW_W-1:0] wIm,
  output logic                   outValid,
  output logic signed [M-1:0]    xRe,
  output logic signed [M-1:0]    xIm,
  output logic signed [M-1:0]    yRe,
  output logic signed [M-1:0]    yIm
);

  bflyStrobe_t strobe;

  dif_bfly_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  dif_bfly_datapath #(
    .N(N), .M(M), .TW_W(TW_W), .SHIFT(SHIFT), .REG_OUT(REG_OUT)
  ) u_dp (
    .clk(clk), .strobe(strobe),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .wRe(wRe), .wIm(wIm),
    .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm)
  );

endmodule

// File: rtl/dif_bfly_chk.sv
module dif_bfly_chk #(
  parameter int N       = 8,
  parameter int M       = 11,
  parameter int TW_W    = 9,
  parameter bit REG_OUT = 1'b1
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   inValid,
  input logic signed [N-1:0]    aRe,
  input logic signed [N-1:0]    aIm,
  input logic signed [N-1:0]    bRe,
  input logic signed [N-1:0]    bIm,
  input logic signed [TW_W-1:0] wRe,
  input logic signed [TW_W-1:0] wIm,
  input logic                   outValid,
  input logic signed [M-1:0]    xRe,
  input logic signed [M-1:0]    xIm,
  input logic signed [M-1:0]    yRe,
  input logic signed [M-1:0]    yIm
);

  generate
    if (REG_OUT) begin : g_reg
      AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
        outValid == $past(inValid) || $past(rst)); // R7
      AST_SUM_REAL: assert property (@(posedge clk) disable iff (rst)
        inValid |=> xRe == M'($past(aRe)) + M'($past(bRe))); // R1
      AST_REAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (inValid && aIm == '0 && bIm == '0) |=> xIm == '0); // R6
      AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!outValid && xRe == '0 && xIm == '0 && yRe == '0 && yIm == '0)); // R8
      AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inValid |=> ($stable(xRe) && $stable(xIm) && $stable(yRe) && $stable(yIm))); // R9
    end else begin : g_comb
      always_comb begin
        AST_COMB_VALID: assert (outValid == inValid); // R7
      end
    end
  endgenerate

endmodule

bind dif_bfly dif_bfly_chk #(.N(N), .M(M), .TW_W(TW_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid),
  .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
  .outValid(outValid), .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm)
);

// File: tb/dif_bfly_bench.sv
`timescale 1ns/1ps
module dif_bfly_bench;

  localparam int N = 8;
  localparam int M = 11;
  localparam int TW_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [N-1:0] aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic signed [TW_W-1:0] wRe = '0, wIm = '0;
  logic outValid;
  logic signed [M-1:0] xRe, xIm, yRe, yIm;

  int checks = 0;
  int errors = 0;
  int expXr, expXi, expYr, expYi;

  always #2 clk = ~clk;

  dif_bfly u_dif_bfly (
    .clk(clk), .rst(rst), .inValid(inValid),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm), .wRe(wRe), .wIm(wIm),
    .outValid(outValid), .xRe(xRe), .xIm(xIm), .yRe(yRe), .yIm(yIm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runVec(input int ar, input int ai, input int br, input int bi,
                        input int wr, input int wi, input string tag);
    int dr, di;
    @(negedge clk);
    aRe = ar[N-1:0]; aIm = ai[N-1:0]; bRe = br[N-1:0]; bIm = bi[N-1:0];
    wRe = wr[TW_W-1:0]; wIm = wi[TW_W-1:0];
    inValid = 1'b1;
    dr = ar - br; di = ai - bi;
    expXr = ar + br; expXi = ai + bi;
    expYr = (dr * wr - di * wi) >>> 8;
    expYi = (dr * wi + di * wr) >>> 8;
    @(negedge clk);
    check(int'(xRe) == expXr, {tag, " R1 xRe"}, int'(xRe), expXr);
    check(int'(xIm) == expXi, {tag, " R1 xIm"}, int'(xIm), expXi);
    check(int'(yRe) == expYr, {tag, " R2 yRe"}, int'(yRe), expYr);
    check(int'(yIm) == expYi, {tag, " R3 yIm"}, int'(yIm), expYi);
    check(outValid == 1'b1, {tag, " R7 outValid"}, int'(outValid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cv[6];
    int tw[6][2];
    int seed;
    cv = '{-128, -127, -1, 0, 1, 127};
    tw = '{'{255, 0}, '{180, -180}, '{0, -255}, '{-180, -180}, '{-256, 0}, '{255, 255}};

    // R8: reset state
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R8 reset outValid", int'(outValid), 0);
    check(xRe == '0 && xIm == '0 && yRe == '0 && yIm == '0, "R8 reset results", int'(yRe), 0);
    rst = 1'b0;

    // R4: floor rounding of negative products
    runVec(0, 0, 1, 0, 255, 0, "R4 floor");
    check(int'(yRe) == -1, "R4 yRe -1", int'(yRe), -1);
    // R5: (255,0) is not a pass-through
    runVec(100, 0, 0, 0, 255, 0, "R5 scale");
    check(int'(yRe) == 99, "R5 yRe 99", int'(yRe), 99);
    runVec(-128, 0, 0, 0, 255, 0, "R5 neg");
    check(int'(yRe) == -128, "R5 yRe -128", int'(yRe), -128);
    // R6: real-only inputs give zero imaginary sum
    runVec(-77, 0, 53, 0, 180, -180, "R6 real");
    check(xIm == '0, "R6 xIm zero", int'(xIm), 0);

    // Corner sweep
    for (int t = 0; t < 6; t++)
      for (int i0 = 0; i0 < 6; i0++)
        for (int i1 = 0; i1 < 6; i1++)
          for (int i2 = 0; i2 < 6; i2++)
            for (int i3 = 0; i3 < 6; i3++)
              runVec(cv[i0], cv[i1], cv[i2], cv[i3], tw[t][0], tw[t][1], "sweep");

    // R9: idle cycle holds results
    runVec(12, -34, 56, -78, 180, -180, "R9 pre");
    @(negedge clk);
    inValid = 1'b0;
    aRe = 8'sd99; bRe = -8'sd5; aIm = 8'sd7; bIm = 8'sd3;
    @(negedge clk);
    check(int'(xRe) == expXr && int'(xIm) == expXi, "R9 hold x", int'(xRe), expXr);
    check(int'(yRe) == expYr && int'(yIm) == expYi, "R9 hold y", int'(yRe), expYr);
    check(outValid == 1'b0, "R7 outValid low", int'(outValid), 0);

    // Pseudo-random run
    seed = 32'h1234_5678;
    for (int k = 0; k < 20000; k++) begin
      int r0, r1, r2, r3, wr, wi;
      seed = seed * 1103515245 + 12345; r0 = ((seed >>> 16) & 255) - 128;
      seed = seed * 1103515245 + 12345; r1 = ((seed >>> 16) & 255) - 128;
      seed = seed * 1103515245 + 12345; r2 = ((seed >>> 16) & 255) - 128;
      seed = seed * 1103515245 + 12345; r3 = ((seed >>> 16) & 255) - 128;
      seed = seed * 1103515245 + 12345; wr = ((seed >>> 16) & 511) - 256;
      seed = seed * 1103515245 + 12345; wi = ((seed >>> 16) & 511) - 256;
      runVec(r0, r1, r2, r3, wr, wi, "random");
    end

    // R8: reset wins over inValid
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; aRe = 8'sd50; bRe = 8'sd20;
    @(negedge clk);
    check(outValid == 1'b0, "R8 reset priority valid", int'(outValid), 0);
    check(xRe == '0 && yRe == '0 && xIm == '0 && yIm == '0, "R8 reset priority data", int'(xRe), 0);
    rst = 1'b0; inValid = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule